// File: doc/BRIEF.md
# Strap-Configured Index/Data Configuration Port

This block is the configuration access point of a multi-function I/O controller. It sits on a simple I/O bus and answers at two addresses: an Index port, which holds a byte that selects one configuration register, and a Data port, through which that register is read or written. A read or write strobe lasts one clock. Read data is driven combinationally during that clock and is qualified by a data-enable output.

While reset is held, two strap inputs choose where the port pair lives and which protocol state the block starts in. With the high strap at 0, the block uses the standard Plug and Play addresses and wakes in Wait-for-Key. In that mode the Index port is write-only, Data writes and Data reads use separate addresses, and the read address is programmable. With the high strap at 1, the block uses one of two read/write address pairs and wakes directly in Config. After reset, software can rewrite a base-address register to move the pair.

The block also holds the activate bit of each logical device. A soft reset restores only these bits. A separate key-match pulse, produced outside this block, moves it from Wait-for-Key to Config.

Top module: `cfg_port_top`

## Requirements
- R1: The straps are sampled only at clock edges while `rst_n` is low. After reset, changing `strap_hi`, `strap_lo` or `act_strap` moves no port and changes no register; only a Data write to index 0x22 moves the pair.
- R2: With location code 00 or 01, the Index port is write-only at 0x0279, so reads there get no `io_rdata_en`. Data writes go to 0x0A79. Data reads come from address {index 0x00 value, 2'b11}, and index 0x00 resets to 0x80, which gives 0x0203.
- R3: With location code 10, the Index port is read/write at 0x015C and the Data port is read/write at 0x015D. Reading the Index port returns the current index.
- R4: With location code 11, the Index port is read/write at 0x002E and the Data port is read/write at 0x002F.
- R5: After reset with `strap_hi`=0 the block is in Wait-for-Key. With `strap_hi`=1 it is in Config, and Data port accesses work at once.
- R6: In Wait-for-Key, Data reads return 0xFF with `io_rdata_en` high, and Data writes are dropped. Index writes are still taken. A one-cycle `key_match` pulse moves the block to Config.
- R7: Bits [1:0] of index 0x22 are the location code. It resets to {strap_hi, strap_hi & strap_lo}. A new value decodes from the bus cycle right after the write.
- R8: Index 0x07 selects a logical device. Bit 0 of index 0x30 is the activate bit of the selected device and appears on `dev_active`. At reset, devices 0 to 2 take `act_strap[2:0]` and all other devices take 0.
- R9: A Data write to index 0x02 with bit 0 set restores every activate bit to its reset value and leaves all other registers unchanged. Bit 1 set returns the block to Wait-for-Key.
- R10: An access counts only on an exact address match with exactly one strobe high. `io_rdata_en` is high only in an accepted read cycle, and `io_rdata` is 0 otherwise.
- R11: Indices 0x20 to 0x2F are byte registers that read back what was written. Unimplemented indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_lo | input | 1 | Low base-address strap |
| strap_hi | input | 1 | High base-address strap, also selects the wake-up state |
| act_strap | input | 3 | Reset activate values of logical devices 0 to 2 |
| key_match | input | 1 | One-cycle pulse from the key detector, leaves Wait-for-Key |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one clock |
| io_rd | input | 1 | Read strobe, one clock |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the read cycle |
| io_rdata_en | output | 1 | High when this block drives the read data |
| dev_active | output | 8 | Activate bit of each logical device |

## Verification
The hardest case to reach is a relocation followed at once by an access at the new address, because the write that moves the pair must itself hit the old Data address. The bench issues bus cycles back to back, so the read at the new Index address falls in the very next cycle. The bench also walks the block from one read/write pair into the standard mode, moves the read-data address, drops back to Wait-for-Key through index 0x02, and leaves it again with a key pulse. This covers every location code and both states without a new reset.

// File: rtl/cfgp_pkg.sv
// Package: shared constants and types for the configuration port.
// Assumes 8-bit configuration indices and 16-bit I/O addresses.
package cfgp_pkg;
    typedef enum logic {
        ST_WAIT_KEY = 1'b0,
        ST_CONFIG   = 1'b1
    } cfg_state_e;

    // Port addresses for each location code
    localparam logic [15:0] PNP_IDX_ADDR  = 16'h0279;
    localparam logic [15:0] PNP_WDAT_ADDR = 16'h0A79;
    localparam logic [15:0] LOC2_IDX_ADDR = 16'h015C;
    localparam logic [15:0] LOC2_DAT_ADDR = 16'h015D;
    localparam logic [15:0] LOC3_IDX_ADDR = 16'h002E;
    localparam logic [15:0] LOC3_DAT_ADDR = 16'h002F;

    // Configuration indices
    localparam logic [7:0] IDX_RDPORT = 8'h00;
    localparam logic [7:0] IDX_CTL    = 8'h02;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_SCR_LO = 8'h20;
    localparam logic [7:0] IDX_BASE   = 8'h22;
    localparam logic [7:0] IDX_ACT    = 8'h30;

    localparam logic [7:0] RDPORT_RST = 8'h80;
endpackage

// File: rtl/cfgp_decode.sv
// Module: address decoder for the Index/Data pair.
// Purely combinational. It turns the current location code and the
// read-data address byte into four hit flags for the present bus address.
// Assumes AW >= 10 so that the read-data address {byte, 2'b11} fits.
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    loc_code,
    input  logic [7:0]    rdport_byte,
    output logic          idx_wr_hit,
    output logic          idx_rd_hit,
    output logic          dat_wr_hit,
    output logic          dat_rd_hit
);
    localparam int PAD = AW - 10;

    logic [AW-1:0] rd_addr;
    assign rd_addr = {{PAD{1'b0}}, rdport_byte, 2'b11};

    // Address compare selected by the location code
    always_comb begin
        idx_wr_hit = 1'b0;
        idx_rd_hit = 1'b0;
        dat_wr_hit = 1'b0;
        dat_rd_hit = 1'b0;
        case (loc_code)
            2'b11: begin
                idx_wr_hit = (addr == AW'(LOC3_IDX_ADDR));
                idx_rd_hit = idx_wr_hit;
                dat_wr_hit = (addr == AW'(LOC3_DAT_ADDR));
                dat_rd_hit = dat_wr_hit;
            end
            2'b10: begin
                idx_wr_hit = (addr == AW'(LOC2_IDX_ADDR));
                idx_rd_hit = idx_wr_hit;
                dat_wr_hit = (addr == AW'(LOC2_DAT_ADDR));
                dat_rd_hit = dat_wr_hit;
            end
            default: begin
                idx_wr_hit = (addr == AW'(PNP_IDX_ADDR));
                dat_wr_hit = (addr == AW'(PNP_WDAT_ADDR));
                dat_rd_hit = (addr == rd_addr);
            end
        endcase
    end
endmodule

// File: rtl/cfgp_state.sv
// Module: protocol state of the port (Wait-for-Key or Config).
// The wake-up state is taken from the high strap while reset is low.
// Assumes key_match and ret_wfk are single-cycle pulses.
module cfgp_state
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_cfg,
    input  logic       key_match,
    input  logic       ret_wfk,
    output cfg_state_e state
);
    // State register with strap-selected reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= wake_cfg ? ST_CONFIG : ST_WAIT_KEY;
        end else begin
            case (state)
                ST_WAIT_KEY: if (key_match) state <= ST_CONFIG;
                default:     if (ret_wfk)   state <= ST_WAIT_KEY;
            endcase
        end
    end
endmodule

// File: rtl/cfgp_regs.sv
// Module: configuration register file.
// Holds the index, the read-data address byte, the device selector, a
// block of byte registers (one of which is the base/location register),
// and the per-device activate bits. Strap values are captured while reset
// is low. Assumes DW = 8 and that the dat_we strobe is already gated by
// the protocol state.
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NDEV   = 8,
    parameter int NSCR   = 16,
    parameter int NSTRAP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi,
    input  logic              strap_lo,
    input  logic [NSTRAP-1:0] act_strap,
    input  logic              idx_we,
    input  logic              dat_we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     index_q,
    output logic [DW-1:0]     rd_data,
    output logic [1:0]        loc_code,
    output logic [7:0]        rdport_q,
    output logic [NDEV-1:0]   dev_act,
    output logic              ret_wfk
);
    localparam int SCR_AW   = $clog2(NSCR);
    localparam int BASE_OFF = int'(IDX_BASE) - int'(IDX_SCR_LO);

    logic [NSCR-1:0][DW-1:0] scr_q;
    logic [DW-1:0]           ldn_q;
    logic [NSTRAP-1:0]       act_strap_q;
    logic [NDEV-1:0]         act_def_in;
    logic [NDEV-1:0]         act_def_q;
    logic                    scr_hit;
    logic [SCR_AW-1:0]       scr_off;
    logic                    soft_rst;
    logic [DW-1:0]           base_rst;

    // Reset defaults per device: strap-driven for the first NSTRAP devices
    for (genvar g = 0; g < NDEV; g++) begin : g_def
        if (g < NSTRAP) begin : g_strap
            assign act_def_in[g] = act_strap[g];
            assign act_def_q[g]  = act_strap_q[g];
        end else begin : g_off
            assign act_def_in[g] = 1'b0;
            assign act_def_q[g]  = 1'b0;
        end
    end

    assign scr_hit  = (int'(index_q) >= int'(IDX_SCR_LO)) &&
                      (int'(index_q) <  int'(IDX_SCR_LO) + NSCR);
    assign scr_off  = SCR_AW'(index_q - DW'(IDX_SCR_LO));
    assign soft_rst = dat_we && (index_q == DW'(IDX_CTL)) && wdata[0];
    assign ret_wfk  = dat_we && (index_q == DW'(IDX_CTL)) && wdata[1];
    assign base_rst = DW'({strap_hi, strap_hi & strap_lo});
    assign loc_code = scr_q[BASE_OFF][1:0];

    // Strap capture for the activate defaults, only while in reset
    always_ff @(posedge clk) begin
        if (!rst_n) act_strap_q <= act_strap;
    end

    // Index register, written through the Index port
    always_ff @(posedge clk) begin
        if (!rst_n)      index_q <= '0;
        else if (idx_we) index_q <= wdata;
    end

    // Read-data address byte and logical-device selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdport_q <= RDPORT_RST;
            ldn_q    <= '0;
        end else if (dat_we) begin
            if (index_q == DW'(IDX_RDPORT)) rdport_q <= wdata[7:0];
            if (index_q == DW'(IDX_LDN))    ldn_q    <= wdata;
        end
    end

    // Byte register block, base/location register included
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSCR; i++) begin
                scr_q[i] <= (i == BASE_OFF) ? base_rst : '0;
            end
        end else if (dat_we && scr_hit) begin
            scr_q[scr_off] <= wdata;
        end
    end

    // Activate bits: reset, soft reset, or write to the selected device
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_act <= act_def_in;
        end else if (soft_rst) begin
            dev_act <= act_def_q;
        end else if (dat_we && (index_q == DW'(IDX_ACT))) begin
            for (int i = 0; i < NDEV; i++) begin
                if (ldn_q == DW'(i)) dev_act[i] <= wdata[0];
            end
        end
    end

    // Read multiplexer for the Data port
    always_comb begin
        rd_data = '0;
        if (index_q == DW'(IDX_RDPORT)) begin
            rd_data = DW'(rdport_q);
        end else if (index_q == DW'(IDX_LDN)) begin
            rd_data = ldn_q;
        end else if (index_q == DW'(IDX_ACT)) begin
            for (int i = 0; i < NDEV; i++) begin
                if (ldn_q == DW'(i)) rd_data = DW'(dev_act[i]);
            end
        end else if (scr_hit) begin
            rd_data = scr_q[scr_off];
        end
    end
endmodule

// File: rtl/cfg_port_top.sv
// Module: strap-configured Index/Data configuration port (top).
// Accepts single-cycle read/write strobes on an I/O bus. It decodes the
// Index/Data pair at the location held in the base register and drives
// read data combinationally in the strobe cycle. Assumes io_rd and io_wr
// are never both meant to be high; such a cycle is ignored.
module cfg_port_top
    import cfgp_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int NDEV   = 8,
    parameter int NSCR   = 16,
    parameter int NSTRAP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_lo,
    input  logic              strap_hi,
    input  logic [NSTRAP-1:0] act_strap,
    input  logic              key_match,
    input  logic [AW-1:0]     io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DW-1:0]     io_wdata,
    output logic [DW-1:0]     io_rdata,
    output logic              io_rdata_en,
    output logic [NDEV-1:0]   dev_active
);
    cfg_state_e    state;
    logic          idx_wr_hit, idx_rd_hit, dat_wr_hit, dat_rd_hit;
    logic [1:0]    loc_code;
    logic [7:0]    rdport_q;
    logic [DW-1:0] index_q;
    logic [DW-1:0] reg_rd;
    logic          ret_wfk;
    logic          wr_ok, rd_ok, idx_we, dat_we;

    assign wr_ok  = io_wr && !io_rd;
    assign rd_ok  = io_rd && !io_wr;
    assign idx_we = wr_ok && idx_wr_hit;
    assign dat_we = wr_ok && dat_wr_hit && (state == ST_CONFIG);

    cfgp_decode #(.AW(AW)) u_decode (
        .addr        (io_addr),
        .loc_code    (loc_code),
        .rdport_byte (rdport_q),
        .idx_wr_hit  (idx_wr_hit),
        .idx_rd_hit  (idx_rd_hit),
        .dat_wr_hit  (dat_wr_hit),
        .dat_rd_hit  (dat_rd_hit)
    );

    cfgp_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_cfg  (strap_hi),
        .key_match (key_match),
        .ret_wfk   (ret_wfk),
        .state     (state)
    );

    cfgp_regs #(
        .DW     (DW),
        .NDEV   (NDEV),
        .NSCR   (NSCR),
        .NSTRAP (NSTRAP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_hi  (strap_hi),
        .strap_lo  (strap_lo),
        .act_strap (act_strap),
        .idx_we    (idx_we),
        .dat_we    (dat_we),
        .wdata     (io_wdata),
        .index_q   (index_q),
        .rd_data   (reg_rd),
        .loc_code  (loc_code),
        .rdport_q  (rdport_q),
        .dev_act   (dev_active),
        .ret_wfk   (ret_wfk)
    );

    // Bus read path: index, register data, or all-ones while locked
    always_comb begin
        io_rdata    = '0;
        io_rdata_en = 1'b0;
        if (rd_ok && idx_rd_hit) begin
            io_rdata    = index_q;
            io_rdata_en = 1'b1;
        end else if (rd_ok && dat_rd_hit) begin
            io_rdata    = (state == ST_CONFIG) ? reg_rd : '1;
            io_rdata_en = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_port_chk.sv
// Module: assertion checker for cfg_port_top, attached by bind.
// Observes bus ports and the decoder, state and register outputs.
module cfg_port_chk
    import cfgp_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_rd,
    input logic          io_wr,
    input logic [DW-1:0] io_wdata,
    input logic [DW-1:0] io_rdata,
    input logic          io_rdata_en,
    input logic          key_match,
    input cfg_state_e    state,
    input logic          dat_rd_hit,
    input logic          dat_we,
    input logic [DW-1:0] index_q,
    input logic [1:0]    loc_code
);
    // Location only moves through a Data write to the base index (R1)
    assert_loc_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_we && index_q == DW'(IDX_BASE)) |=> $stable(loc_code));

    // A write to the base index takes effect on the next cycle (R7)
    assert_loc_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && index_q == DW'(IDX_BASE)) |=> loc_code == $past(io_wdata[1:0]));

    // Locked Data reads return all ones (R6)
    assert_locked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_KEY && io_rd && !io_wr && dat_rd_hit)
            |-> (io_rdata_en && io_rdata == '1));

    // No Data write is accepted while locked (R6)
    assert_locked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_KEY) |-> !dat_we);

    // A key pulse leaves Wait-for-Key (R6)
    assert_key_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_KEY && key_match) |=> state == ST_CONFIG);

    // Read enable only in a clean read cycle (R10)
    assert_en_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_en |-> (io_rd && !io_wr));

    // Bus data is zero when not driven (R10)
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rdata_en |-> io_rdata == '0);

    // Soft reset leaves index and location untouched (R9)
    assert_soft_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && index_q == DW'(IDX_CTL) && io_wdata[0] && !io_wdata[1])
            |=> ($stable(index_q) && $stable(loc_code)));
endmodule

bind cfg_port_top cfg_port_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .io_rdata_en (io_rdata_en),
    .key_match   (key_match),
    .state       (state),
    .dat_rd_hit  (dat_rd_hit),
    .dat_we      (dat_we),
    .index_q     (index_q),
    .loc_code    (loc_code)
);

// File: tb/cfg_port_top_test.sv
// Scoreboard bench: read tasks queue the expected item, a monitor at the
// falling edge pops and compares it with the bus result.
module cfg_port_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_lo = 1'b0, strap_hi = 1'b0;
    logic [2:0]  act_strap = 3'b000;
    logic        key_match = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_en;
    logic [7:0]  dev_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] val;
        logic       en;
        string      req;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;   // 50 MHz

    cfg_port_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_lo    (strap_lo),
        .strap_hi    (strap_hi),
        .act_strap   (act_strap),
        .key_match   (key_match),
        .io_addr     (io_addr),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .io_rdata_en (io_rdata_en),
        .dev_active  (dev_active)
    );

    // Monitor: compare each read cycle with the queued expectation
    always @(negedge clk) begin
        if (rst_n && io_rd) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: en=%0b data=%02h expected nothing", io_rdata_en, io_rdata);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (io_rdata_en !== e.en || (e.en && io_rdata !== e.val)) begin
                    fails++;
                    $display("FAIL %s addr=%04h: got en=%0b data=%02h, expected en=%0b data=%02h",
                             e.req, io_addr, io_rdata_en, io_rdata, e.en, e.val);
                end
            end
        end
    end

    // Tasks start at posedge+2 and end at the next posedge+2
    task automatic cyc();
        @(posedge clk); #2;
        io_wr = 1'b0; io_rd = 1'b0; key_match = 1'b0;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        cyc();
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] v,
                          input logic en, input string req);
        exp_t e;
        e.val = v; e.en = en; e.req = req;
        sbq.push_back(e);
        io_addr = a; io_rd = 1'b1;
        cyc();
    endtask

    task automatic bus_both(input logic [15:0] a, input logic [7:0] d, input string req);
        exp_t e;
        e.val = 8'h00; e.en = 1'b0; e.req = req;
        sbq.push_back(e);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b1;
        cyc();
    endtask

    task automatic key_pulse();
        key_match = 1'b1;
        cyc();
    endtask

    task automatic chk_dev(input logic [7:0] exp, input string req);
        checks++;
        if (dev_active !== exp) begin
            fails++;
            $display("FAIL %s dev_active: got %02h, expected %02h", req, dev_active, exp);
        end
    endtask

    task automatic do_reset(input logic hi, input logic lo, input logic [2:0] act);
        strap_hi = hi; strap_lo = lo; act_strap = act;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        // ---- Straps 1/1: read/write pair at 0x2E/0x2F, Config state
        do_reset(1'b1, 1'b1, 3'b101);
        bus_rd(16'h002F, 8'h80, 1'b1, "R5 config on wake, R4 data port");
        chk_dev(8'h05, "R8 strap activate defaults");
        bus_wr(16'h002E, 8'h21);
        bus_wr(16'h002F, 8'h5A);
        bus_rd(16'h002E, 8'h21, 1'b1, "R4 index readback");
        bus_rd(16'h002F, 8'h5A, 1'b1, "R11 byte register");
        strap_hi = 1'b0; strap_lo = 1'b0; act_strap = 3'b010;
        bus_rd(16'h002F, 8'h5A, 1'b1, "R1 straps ignored after reset");
        bus_rd(16'h015D, 8'h00, 1'b0, "R10 no response off-address");
        bus_wr(16'h002E, 8'h40);
        bus_rd(16'h002F, 8'h00, 1'b1, "R11 unimplemented index");
        bus_wr(16'h002E, 8'h22);
        bus_rd(16'h002F, 8'h03, 1'b1, "R7 base reset value");
        bus_wr(16'h002E, 8'h07); bus_wr(16'h002F, 8'h05);
        bus_wr(16'h002E, 8'h30); bus_wr(16'h002F, 8'h01);
        chk_dev(8'h25, "R8 activate device 5");
        bus_rd(16'h002F, 8'h01, 1'b1, "R8 activate readback");
        bus_wr(16'h002E, 8'h07); bus_wr(16'h002F, 8'h00);
        bus_wr(16'h002E, 8'h30); bus_wr(16'h002F, 8'h00);
        chk_dev(8'h24, "R8 deactivate device 0");
        bus_wr(16'h002E, 8'h02); bus_wr(16'h002F, 8'h01);
        chk_dev(8'h05, "R9 soft reset restores activate");
        bus_wr(16'h002E, 8'h21);
        bus_rd(16'h002F, 8'h5A, 1'b1, "R9 soft reset keeps registers");
        bus_wr(16'h002E, 8'h07);
        bus_rd(16'h002F, 8'h00, 1'b1, "R9 soft reset keeps selector");
        bus_both(16'h002E, 8'h77, "R10 dual strobe ignored");
        bus_rd(16'h002E, 8'h07, 1'b1, "R10 index unchanged by dual strobe");
        // ---- Relocation to 0x15C/0x15D, then to standard addresses
        bus_wr(16'h002E, 8'h22);
        bus_wr(16'h002F, 8'h02);
        bus_rd(16'h015C, 8'h22, 1'b1, "R7 R3 new index port next cycle");
        bus_rd(16'h002E, 8'h00, 1'b0, "R7 old pair released");
        bus_rd(16'h015D, 8'h02, 1'b1, "R3 data port");
        bus_wr(16'h015D, 8'h00);
        bus_rd(16'h0203, 8'h00, 1'b1, "R2 R7 read port after move");
        bus_rd(16'h0279, 8'h00, 1'b0, "R2 index port write-only");
        bus_wr(16'h0279, 8'h21); bus_wr(16'h0A79, 8'h77);
        bus_rd(16'h0203, 8'h77, 1'b1, "R2 write then read ports");
        bus_wr(16'h0279, 8'h00); bus_wr(16'h0A79, 8'h90);
        bus_rd(16'h0243, 8'h90, 1'b1, "R2 read port moved");
        bus_rd(16'h0203, 8'h00, 1'b0, "R2 old read port released");
        // ---- Back to Wait-for-Key, then key exit
        bus_wr(16'h0279, 8'h02); bus_wr(16'h0A79, 8'h02);
        bus_rd(16'h0243, 8'hFF, 1'b1, "R9 R6 locked read");
        bus_wr(16'h0279, 8'h21); bus_wr(16'h0A79, 8'h11);
        key_pulse();
        bus_rd(16'h0243, 8'h77, 1'b1, "R6 locked write dropped, key exit");
        // ---- Straps 0/1: standard addresses, Wait-for-Key
        do_reset(1'b0, 1'b1, 3'b010);
        chk_dev(8'h02, "R8 strap activate defaults");
        bus_rd(16'h0203, 8'hFF, 1'b1, "R5 R6 wake locked");
        key_pulse();
        bus_wr(16'h0279, 8'h22);
        bus_rd(16'h0203, 8'h00, 1'b1, "R7 R2 base reset with high strap 0");
        bus_rd(16'h002E, 8'h00, 1'b0, "R2 other pair unused");
        // ---- Straps 1/0: pair at 0x15C/0x15D, Config state
        do_reset(1'b1, 1'b0, 3'b000);
        chk_dev(8'h00, "R8 strap activate defaults");
        bus_rd(16'h015C, 8'h00, 1'b1, "R3 index port");
        bus_wr(16'h015C, 8'h22);
        bus_rd(16'h015D, 8'h02, 1'b1, "R3 R7 R5 base value in config");
        bus_rd(16'h015C, 8'h22, 1'b1, "R3 index readback");
        bus_rd(16'h002F, 8'h00, 1'b0, "R3 other pair unused");

        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule